// File: doc/BRIEF.md
# Selectable Quadrature and Pulse Decoder

This block turns the raw A, B and index inputs of one encoder channel into single-cycle count-up and count-down strobes, a direction level, an index strobe and a sticky noise flag. It decodes four count functions: pulse with direction, and quadrature at x1, x2 and x4 resolution. A 2-bit select picks the function at run time, and a downstream counter consumes the strobes.

Each raw input passes through a two-stage synchronizer and then a digital filter. The filter samples only on ticks of a programmable prescaler. An input level is accepted only once two consecutive filter ticks have seen it. In quadrature operation, a filtered update that changes A and B at the same time cannot be decoded. Such an update raises a noise flag, which holds until it is cleared.

The index input has a selectable active level. It can also be gated so that in quadrature operation it only fires while both A and B are high. An enable input suppresses every strobe while the input filters keep tracking the lines.

Top module: `quad_pulse_decoder`

## Requirements
- R1: During and after synchronous reset, all three strobes and the noise flag are 0 and the direction level is 1. The function select is decoded as 0 = pulse/direction, 1 = x1, 2 = x2, 3 = x4. The prescaler reset default is 0.
- R2: With select 0, a filtered rising edge of A produces an up strobe when filtered B is 1 and a down strobe when B is 0. The direction level follows filtered B. A and B changing together never raise the noise flag in this function.
- R3: With select 1, a step counts only when A changes while B is 0. A rising with B at 0 gives an up strobe, and A falling with B at 0 gives a down strobe. A full forward cycle therefore yields exactly one up strobe, and a full backward cycle exactly one down strobe.
- R4: With select 2, every single-line change of A gives one strobe. Changes of B alone give none. A full cycle yields two strobes.
- R5: With select 3, every single-line change of A or B gives one strobe, so a full cycle yields four. The direction comes from the phase order, and A leading B means up: {A,B} stepping 00,10,11,01 is up. The direction level keeps the direction of the last decoded step.
- R6: The filter ticks once every prescaler+1 clocks. A synchronized level is accepted only if it is seen on two consecutive ticks. A pulse shorter than one tick interval produces no strobe.
- R7: In select 1 to 3, a filtered update in which A and B change together sets the noise flag and produces no strobe. The flag stays set until the clear input is 1, and it reads 0 on the cycle after that.
- R8: While the enable input is 0, no up, down or index strobe is produced and no noise is recorded. The filters and the previous-sample state keep tracking, so re-enabling produces no stale strobe.
- R9: The index strobe fires once when filtered index enters its active level: high when the polarity input is 1, low when it is 0. A change of the polarity input alone produces no strobe.
- R10: With the synchronous-index input at 1 and select 1 to 3, the index strobe fires only if filtered A and B are both 1. With select 0 the synchronous-index input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Count function: 0 pulse/direction, 1 x1, 2 x2, 3 x4 |
| presc_val | input | PRESC_W | Filter prescaler; tick every presc_val+1 clocks |
| count_en | input | 1 | Enables strobes and noise detection |
| idx_pol | input | 1 | Index active level: 1 high, 0 low |
| idx_sync | input | 1 | Gate index with A and B both high in quadrature functions |
| err_clr | input | 1 | Clears the noise flag |
| in_a | input | 1 | Raw A input |
| in_b | input | 1 | Raw B input |
| in_idx | input | 1 | Raw index input |
| up_stb | output | 1 | One-cycle count-up strobe |
| dn_stb | output | 1 | One-cycle count-down strobe |
| dir_up | output | 1 | Direction level, 1 = up |
| idx_stb | output | 1 | One-cycle index strobe |
| noise_err | output | 1 | Sticky noise flag |

## Verification
A raw edge passes two synchronizer flops and needs two filter ticks. It then takes one output register, so at prescaler 0 a strobe appears five clocks after the input changes. In general the delay is up to 2(P+1)+3 clocks for prescaler P. The noise flag clears one clock after the clear input. The bench holds every input level for 2(P+1)+6 clocks, which lets each decoded step finish before the next one starts. A behavioural model with the same latency is compared with every output on each falling clock edge. Per-phase strobe tallies are checked only after the last hold has drained.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [1:0] {
    MODE_PD = 2'd0,
    MODE_X1 = 2'd1,
    MODE_X2 = 2'd2,
    MODE_X4 = 2'd3
  } qd_mode_t;

  localparam int unsigned LANE_A   = 0;
  localparam int unsigned LANE_B   = 1;
  localparam int unsigned LANE_IDX = 2;
  localparam int unsigned NUM_LANES = 3;
endpackage

// File: rtl/qd_tick_gen.sv
module qd_tick_gen #(
  parameter int unsigned PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] presc_val,
  output logic               tick
);
  logic [PRESC_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (div_cnt >= presc_val) begin
      div_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      tick    <= 1'b0;
    end
  end

  // R6
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && presc_val != '0) |=> !tick);
endmodule

// File: rtl/qd_input_filter.sv
module qd_input_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw_in,
  output logic filt_out
);
  localparam int unsigned SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] sync_sh;
  logic          synced;
  logic          last_sample;

  always_ff @(posedge clk) begin
    if (rst) sync_sh <= '0;
    else     sync_sh <= {sync_sh[SW-2:0], raw_in};
  end

  assign synced = sync_sh[SW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      last_sample <= 1'b0;
      filt_out    <= 1'b0;
    end else if (tick) begin
      last_sample <= synced;
      if (synced == last_sample) filt_out <= synced;
    end
  end

  // R6
  filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(filt_out));
endmodule

// File: rtl/qd_step_decode.sv
module qd_step_decode
  import qd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  qd_mode_t mode,
  input  logic     en,
  input  logic     err_clr,
  input  logic     fa,
  input  logic     fb,
  output logic     up_stb,
  output logic     dn_stb,
  output logic     dir_up,
  output logic     noise_err
);
  logic pa, pb;
  logic chg_a, chg_b, only_a, only_b, clash;
  logic step_fwd, step_ok, noise_set;

  assign chg_a  = fa ^ pa;
  assign chg_b  = fb ^ pb;
  assign only_a = chg_a & ~chg_b;
  assign only_b = chg_b & ~chg_a;
  assign clash  = chg_a & chg_b;

  // phase order: after a lone A change, A differing from B means A led
  assign step_fwd = only_a ? (fa ^ fb) : ~(fa ^ fb);

  always_comb begin
    unique case (mode)
      MODE_X1: step_ok = only_a & ~fb;
      MODE_X2: step_ok = only_a;
      MODE_X4: step_ok = only_a | only_b;
      default: step_ok = 1'b0;
    endcase
  end

  assign noise_set = en & clash & (mode != MODE_PD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pa        <= 1'b0;
      pb        <= 1'b0;
      up_stb    <= 1'b0;
      dn_stb    <= 1'b0;
      dir_up    <= 1'b1;
      noise_err <= 1'b0;
    end else begin
      pa        <= fa;
      pb        <= fb;
      noise_err <= (noise_err & ~err_clr) | noise_set;
      if (mode == MODE_PD) begin
        dir_up <= fb;
        up_stb <= en & chg_a & fa & fb;
        dn_stb <= en & chg_a & fa & ~fb;
      end else begin
        if (en && (only_a || only_b)) dir_up <= step_fwd;
        up_stb <= en & step_ok & step_fwd;
        dn_stb <= en & step_ok & ~step_fwd;
      end
    end
  end

  // R7
  noise_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (noise_err && !err_clr) |=> noise_err);
  // R2
  pd_no_noise_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PD && !noise_err) |=> !noise_err);
  // R8
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!up_stb && !dn_stb));
  // R3
  x1_b_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_X1 && fb) |=> (!up_stb && !dn_stb));
endmodule

// File: rtl/qd_index_gate.sv
module qd_index_gate
  import qd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  qd_mode_t mode,
  input  logic     en,
  input  logic     pol,
  input  logic     sync_req,
  input  logic     fa,
  input  logic     fb,
  input  logic     fi,
  output logic     idx_stb
);
  logic pi;
  logic now_act, was_act, gate_ok;

  // compare both samples against the current polarity
  assign now_act = (fi == pol);
  assign was_act = (pi == pol);
  assign gate_ok = ~sync_req | (mode == MODE_PD) | (fa & fb);

  always_ff @(posedge clk) begin
    if (rst) begin
      pi      <= 1'b0;
      idx_stb <= 1'b0;
    end else begin
      pi      <= fi;
      idx_stb <= en & now_act & ~was_act & gate_ok;
    end
  end

  // R10
  sync_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_req && mode != MODE_PD && !(fa && fb)) |=> !idx_stb);
  // R8
  idx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !idx_stb);
endmodule

// File: rtl/quad_pulse_decoder.sv
module quad_pulse_decoder
  import qd_pkg::*;
#(
  parameter int unsigned PRESC_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode_sel,
  input  logic [PRESC_W-1:0] presc_val,
  input  logic               count_en,
  input  logic               idx_pol,
  input  logic               idx_sync,
  input  logic               err_clr,
  input  logic               in_a,
  input  logic               in_b,
  input  logic               in_idx,
  output logic               up_stb,
  output logic               dn_stb,
  output logic               dir_up,
  output logic               idx_stb,
  output logic               noise_err
);
  logic                 tick;
  logic [NUM_LANES-1:0] raw_lanes;
  logic [NUM_LANES-1:0] filt_lanes;
  qd_mode_t             mode;

  assign mode = qd_mode_t'(mode_sel);

  assign raw_lanes[LANE_A]   = in_a;
  assign raw_lanes[LANE_B]   = in_b;
  assign raw_lanes[LANE_IDX] = in_idx;

  qd_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .presc_val (presc_val),
    .tick      (tick)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    qd_input_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .raw_in   (raw_lanes[g]),
      .filt_out (filt_lanes[g])
    );
  end

  qd_step_decode u_step (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .en        (count_en),
    .err_clr   (err_clr),
    .fa        (filt_lanes[LANE_A]),
    .fb        (filt_lanes[LANE_B]),
    .up_stb    (up_stb),
    .dn_stb    (dn_stb),
    .dir_up    (dir_up),
    .noise_err (noise_err)
  );

  qd_index_gate u_idx (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .en       (count_en),
    .pol      (idx_pol),
    .sync_req (idx_sync),
    .fa       (filt_lanes[LANE_A]),
    .fb       (filt_lanes[LANE_B]),
    .fi       (filt_lanes[LANE_IDX]),
    .idx_stb  (idx_stb)
  );
endmodule

// File: tb/quad_pulse_decoder_test.sv
`timescale 1ns/1ps
module quad_pulse_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic [7:0] presc_val = 8'd0;
  logic       count_en = 1'b1;
  logic       idx_pol = 1'b1;
  logic       idx_sync = 1'b0;
  logic       err_clr = 1'b0;
  logic       in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0;
  logic       up_stb, dn_stb, dir_up, idx_stb, noise_err;

  always #2 clk = ~clk;

  quad_pulse_decoder uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .presc_val(presc_val),
    .count_en(count_en), .idx_pol(idx_pol), .idx_sync(idx_sync),
    .err_clr(err_clr), .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
    .up_stb(up_stb), .dn_stb(dn_stb), .dir_up(dir_up),
    .idx_stb(idx_stb), .noise_err(noise_err)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  int    t_up = 0, t_dn = 0, t_idx = 0;

  // behavioural reference model
  int ms1[3], ms2[3], msamp[3], mf[3], mp[3];
  int mcnt = 0;
  bit mtick = 0;
  bit m_up = 0, m_dn = 0, m_dir = 1, m_idx = 0, m_err = 0;

  always @(posedge clk) begin
    int raw[3];
    bit fa, fb, da, db, sa, sb, fwd, ok, nset, act, pact, gate;
    raw[0] = in_a; raw[1] = in_b; raw[2] = in_idx;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        ms1[i] = 0; ms2[i] = 0; msamp[i] = 0; mf[i] = 0; mp[i] = 0;
      end
      mcnt = 0; mtick = 0;
      m_up = 0; m_dn = 0; m_dir = 1; m_idx = 0; m_err = 0;
    end else begin
      fa = (mf[0] != 0); fb = (mf[1] != 0);
      da = (mf[0] != mp[0]); db = (mf[1] != mp[1]);
      nset = 0;
      if (mode_sel == 2'd0) begin
        m_dir = fb;
        m_up  = count_en && da && fa && fb;
        m_dn  = count_en && da && fa && !fb;
      end else begin
        sa  = da && !db;
        sb  = db && !da;
        fwd = sa ? (fa != fb) : (fa == fb);
        if (mode_sel == 2'd1)      ok = sa && !fb;
        else if (mode_sel == 2'd2) ok = sa;
        else                       ok = sa || sb;
        m_up = count_en && ok && fwd;
        m_dn = count_en && ok && !fwd;
        if (count_en && (sa || sb)) m_dir = fwd;
        nset = count_en && da && db;
      end
      m_err = (m_err && !err_clr) || nset;
      act  = ((mf[2] != 0) == idx_pol);
      pact = ((mp[2] != 0) == idx_pol);
      gate = !idx_sync || (mode_sel == 2'd0) || (fa && fb);
      m_idx = count_en && act && !pact && gate;
      for (int i = 0; i < 3; i++) mp[i] = mf[i];
      if (mtick)
        for (int i = 0; i < 3; i++) begin
          if (ms2[i] == msamp[i]) mf[i] = ms2[i];
          msamp[i] = ms2[i];
        end
      for (int i = 0; i < 3; i++) begin
        ms2[i] = ms1[i];
        ms1[i] = raw[i];
      end
      if (mcnt >= int'(presc_val)) begin mcnt = 0; mtick = 1; end
      else begin mcnt = mcnt + 1; mtick = 0; end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_vec++;
      if ({up_stb, dn_stb, dir_up, idx_stb, noise_err} !==
          {m_up, m_dn, m_dir, m_idx, m_err}) begin
        n_bad++;
        $display("FAIL %s: up/dn/dir/idx/err actual %b%b%b%b%b expected %b%b%b%b%b at %0t",
                 cur_req, up_stb, dn_stb, dir_up, idx_stb, noise_err,
                 m_up, m_dn, m_dir, m_idx, m_err, $time);
      end
      if (up_stb === 1'b1) t_up++;
      if (dn_stb === 1'b1) t_dn++;
      if (idx_stb === 1'b1) t_idx++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int hold_len();
    return 2 * (int'(presc_val) + 1) + 6;
  endfunction

  task automatic ab(input bit a, input bit b);
    in_a = a; in_b = b;
    cyc(hold_len());
  endtask

  task automatic idx_lvl(input bit v);
    in_idx = v;
    cyc(hold_len());
  endtask

  task automatic phase(input string req);
    cur_req = req;
    t_up = 0; t_dn = 0; t_idx = 0;
  endtask

  task automatic tally(input string req, input int eu, input int ed, input int ei);
    n_vec++;
    if (t_up != eu || t_dn != ed || t_idx != ei) begin
      n_bad++;
      $display("FAIL %s: strobe tally up/dn/idx actual %0d/%0d/%0d expected %0d/%0d/%0d",
               req, t_up, t_dn, t_idx, eu, ed, ei);
    end
  endtask

  task automatic lvl(input string req, input string what, input bit act, input bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic fwd_cycle();
    ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
  endtask

  task automatic back_cycle();
    ab(0, 1); ab(1, 1); ab(1, 0); ab(0, 0);
  endtask

  initial begin
    fork
      begin
        // R1 reset state
        cyc(3);
        cmp_on = 1'b1;
        @(negedge clk);
        lvl("R1", "reset outputs up,dn,idx,err", up_stb | dn_stb | idx_stb | noise_err, 1'b0);
        lvl("R1", "reset dir_up", dir_up, 1'b1);
        cyc(1);
        rst = 1'b0;
        cyc(4);

        // R2 pulse/direction
        phase("R2");
        ab(0, 1); ab(1, 1); ab(0, 1); ab(1, 1); ab(0, 1);
        ab(0, 0); ab(1, 0); ab(0, 0);
        tally("R2", 2, 1, 0);
        @(negedge clk);
        lvl("R2", "dir_up with B low", dir_up, 1'b0);
        #1;
        ab(1, 1); ab(0, 0);
        @(negedge clk);
        lvl("R2", "noise flag after joint change", noise_err, 1'b0);
        #1;

        // R3 x1
        mode_sel = 2'd1;
        phase("R3");
        fwd_cycle();
        tally("R3", 1, 0, 0);
        phase("R3");
        back_cycle();
        tally("R3", 0, 1, 0);

        // R4 x2
        mode_sel = 2'd2;
        phase("R4");
        fwd_cycle();
        tally("R4", 2, 0, 0);
        phase("R4");
        back_cycle();
        tally("R4", 0, 2, 0);

        // R5 x4
        mode_sel = 2'd3;
        phase("R5");
        fwd_cycle();
        tally("R5", 4, 0, 0);
        @(negedge clk);
        lvl("R5", "dir_up after forward cycle", dir_up, 1'b1);
        #1;
        phase("R5");
        back_cycle();
        tally("R5", 0, 4, 0);
        @(negedge clk);
        lvl("R5", "dir_up after backward cycle", dir_up, 1'b0);
        #1;

        // R6 filter with prescaler 3
        presc_val = 8'd3;
        cyc(8);
        phase("R6");
        in_a = 1'b1; cyc(2); in_a = 1'b0;
        cyc(hold_len());
        tally("R6", 0, 0, 0);
        phase("R6");
        ab(1, 0); ab(0, 0);
        tally("R6", 1, 1, 0);
        presc_val = 8'd0;
        cyc(8);

        // R7 noise flag
        phase("R7");
        ab(1, 1);
        tally("R7", 0, 0, 0);
        ab(0, 0);
        @(negedge clk);
        lvl("R7", "noise flag sticky", noise_err, 1'b1);
        #1;
        err_clr = 1'b1; cyc(1); err_clr = 1'b0;
        @(negedge clk);
        lvl("R7", "noise flag after clear", noise_err, 1'b0);
        #1;

        // R8 enable off
        phase("R8");
        count_en = 1'b0;
        ab(1, 0);
        idx_lvl(1); idx_lvl(0);
        count_en = 1'b1;
        cyc(hold_len());
        tally("R8", 0, 0, 0);
        phase("R8");
        ab(1, 1);
        tally("R8", 1, 0, 0);
        ab(0, 1); ab(0, 0);

        // R9 index polarity
        mode_sel = 2'd0;
        phase("R9");
        idx_lvl(1); idx_lvl(0);
        tally("R9", 0, 0, 1);
        phase("R9");
        idx_pol = 1'b0;
        cyc(hold_len());
        tally("R9", 0, 0, 0);
        idx_lvl(1); idx_lvl(0);
        tally("R9", 0, 0, 1);
        idx_pol = 1'b1;
        cyc(hold_len());

        // R10 synchronous index
        mode_sel = 2'd3;
        idx_sync = 1'b1;
        phase("R10");
        idx_lvl(1); idx_lvl(0);
        tally("R10", 0, 0, 0);
        ab(1, 0); ab(1, 1);
        phase("R10");
        idx_lvl(1); idx_lvl(0);
        tally("R10", 0, 0, 1);
        ab(0, 1); ab(0, 0);
        mode_sel = 2'd0;
        phase("R10");
        idx_lvl(1); idx_lvl(0);
        tally("R10", 0, 0, 1);
        idx_sync = 1'b0;
      end
      begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule